// File: doc/BRIEF.md
# Serial ADC Conversion Host Controller

This block is a synchronous master for an eight-channel, ten-bit serial converter run from an external serial clock. It generates an active-low chip select and the serial clock, sends an eight-bit command on the converter's data input, and reassembles the ten-bit result from the converter's data output. Result words leave the block with a one-cycle valid strobe.

While the start request is held high, conversions run back to back at one every 16 serial clocks. The start bit of the next command goes out during the last three result bits of the previous conversion. When the request drops, the last conversion ends with an eight-clock tail, 24 clocks in total, and chip select is then released. After reset the block waits for the converter's power-on interval before it lowers chip select for the first time.

The serial clock rate comes from the system clock frequency. A parameter sets the clock ceiling: 2 MHz by default, or 400 kHz for a converter that has no external reference capacitor.

Top module: `adc_host`

## Requirements
- R1: During and right after reset, `csN` is 1, `sclk` is 0, `din` is 0 and `resultValid` is 0. `sclk` stays low whenever `csN` is high.
- R2: `csN` does not fall until SYS_CLK_HZ/1e6 × POWERUP_US system cycles after reset release. It falls within one half serial period after that.
- R3: The command is sent MSB first on rising `sclk` clocks 1 to 8 of a frame. Its bits are 1 (start), `chanSel[2:0]`, `uniPolar`, `singleEnded`, `pwrDown[1:0]`. `din` changes only while `sclk` is low.
- R4: `din` is 0 on every rising `sclk` edge of a frame other than its eight command clocks. This includes the tail clocks 17 to 24.
- R5: Each `sclk` half period lasts ceil(SYS_CLK_HZ / (2 × cap)) system cycles. The cap is 2 MHz when SCLK_CAP_LOW is 0 and 400 kHz when it is 1.
- R6: While `startReq` is high at the end of clock 16, the next frame follows at once and `csN` stays low. Consecutive `resultValid` pulses in one chip-select session are 32 half periods apart.
- R7: `result` holds the ten bits sampled from `dout` on the rising `sclk` edges of clocks 10 to 19 of the frame, counted across the frame boundary, with the first sampled bit as MSB. The two sub-LSB bits and the fill bits are discarded.
- R8: `resultValid` is a one-cycle pulse. `result` changes only in the cycle where `resultValid` is high.
- R9: If `startReq` is low at the end of clock 16, the frame continues to clock 24 with `din` at 0 and then raises `csN`. A session of N conversions therefore has 16N + 8 rising `sclk` edges.
- R10: The command fields are latched when a frame's command is loaded. Changing them later in the frame has no effect on the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Request to convert; held high to chain frames |
| chanSel | input | 3 | Channel select field of the command |
| uniPolar | input | 1 | 1 = unipolar, 0 = bipolar coding |
| singleEnded | input | 1 | 1 = single-ended, 0 = differential input |
| pwrDown | input | 2 | Power-down mode field of the command |
| dout | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| csN | output | 1 | Active-low chip select |
| din | output | 1 | Serial command data to the converter |
| result | output | 10 | Last reassembled conversion code |
| resultValid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The hardest case to reach is the frame seam. There the next start bit goes out while the previous result's last three bits are still arriving, and the command fields change in the middle of a frame. The stimulus holds `startReq` across random burst lengths so that many seams occur. A behavioural converter model returns random codes and random sub-LSB bits. It re-randomizes the command fields after the fourth command bit of each frame, so a command that was not latched shows up as a wrong byte.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int CMD_BITS   = 8;
  localparam int RES_BITS   = 10;
  localparam int FRAME_CLKS = 16;
  localparam int POS_W      = 5;
  localparam int RES_FIRST  = CMD_BITS + 2;
  localparam int RES_LAST   = RES_FIRST + RES_BITS - 1;
  localparam int TAIL_LAST  = FRAME_CLKS + CMD_BITS;
  localparam int WRAP_LAST  = RES_LAST - FRAME_CLKS;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} seqState_t;

  typedef struct packed {
    logic loadCmd;
    logic shiftCmd;
    logic sampleBit;
    logic pushResult;
  } dpCtl_t;
endpackage

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ   = 125_000_000,
  parameter bit          SCLK_CAP_LOW = 1'b0,
  parameter int unsigned POWERUP_US   = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  output logic             sclk,
  output logic             csN,
  output logic [POS_W-1:0] framePos,
  output dpCtl_t           dpCtl
);
  localparam int unsigned CAP_HZ   = SCLK_CAP_LOW ? 400_000 : 2_000_000;
  localparam int unsigned HALF_DIV = (SYS_CLK_HZ + 2 * CAP_HZ - 1) / (2 * CAP_HZ);
  localparam int unsigned WAIT_CYC = (SYS_CLK_HZ / 1_000_000) * POWERUP_US;
  localparam int DIV_W  = $clog2(HALF_DIV + 1);
  localparam int WAIT_W = $clog2(WAIT_CYC + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYC - 1);
  localparam logic [POS_W-1:0]  P_ONE   = POS_W'(1);
  localparam logic [POS_W-1:0]  P_FRAME = POS_W'(FRAME_CLKS);
  localparam logic [POS_W-1:0]  P_TAIL  = POS_W'(TAIL_LAST);
  localparam logic [POS_W-1:0]  P_RFST  = POS_W'(RES_FIRST);
  localparam logic [POS_W-1:0]  P_RLST  = POS_W'(RES_LAST);
  localparam logic [POS_W-1:0]  P_WRAP  = POS_W'(WRAP_LAST);

  logic [DIV_W-1:0]  divCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              ready;
  logic              tick;
  seqState_t         state;
  logic [POS_W-1:0]  pos;
  logic              pending;
  logic              startNow, atRise, atFall, chain, inWin;

  assign tick     = (divCnt == DIV_LAST);
  assign framePos = pos;

  always_ff @(posedge clk) begin
    if (rst || tick) divCnt <= '0;
    else             divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waitCnt <= '0;
      ready   <= 1'b0;
    end else if (!ready) begin
      if (waitCnt == WAIT_LAST) ready <= 1'b1;
      else                      waitCnt <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    startNow = tick && (state == ST_IDLE) && ready && startReq;
    atRise   = tick && (state != ST_IDLE) && !sclk;
    atFall   = tick && (state != ST_IDLE) && sclk;
    chain    = atFall && (state == ST_RUN) && (pos == P_FRAME) && startReq;
    inWin    = ((pos >= P_RFST) && (pos <= P_RLST)) || (pending && (pos <= P_WRAP));
    dpCtl.loadCmd    = startNow || chain;
    dpCtl.shiftCmd   = atFall && !chain;
    dpCtl.sampleBit  = atRise && inWin;
    dpCtl.pushResult = atRise && ((pos == P_RLST) || (pending && (pos == P_WRAP)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sclk    <= 1'b0;
      csN     <= 1'b1;
      pos     <= '0;
      pending <= 1'b0;
    end else begin
      if (dpCtl.pushResult) pending <= 1'b0;
      if (startNow) begin
        csN   <= 1'b0;
        pos   <= P_ONE;
        state <= ST_RUN;
      end else if (atRise) begin
        sclk <= 1'b1;
      end else if (atFall) begin
        sclk <= 1'b0;
        if (state == ST_RUN && pos == P_FRAME) begin
          if (startReq) begin
            pos     <= P_ONE;
            pending <= 1'b1;
          end else begin
            pos   <= pos + 1'b1;
            state <= ST_TAIL;
          end
        end else if (state == ST_TAIL && pos == P_TAIL) begin
          csN   <= 1'b1;
          state <= ST_IDLE;
          pos   <= '0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  AST_HOLD_BEFORE_READY: assert property (@(posedge clk) disable iff (rst) !ready |-> csN); // R2
  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst) csN |-> !sclk); // R1
  AST_FRAME_BOUNDS: assert property (@(posedge clk) disable iff (rst) !csN |-> (pos >= P_ONE && pos <= P_TAIL)); // R9
endmodule

// File: rtl/adc_host_dp.sv
module adc_host_dp
  import adc_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  dpCtl_t              dpCtl,
  input  logic [2:0]          chanSel,
  input  logic                uniPolar,
  input  logic                singleEnded,
  input  logic [1:0]          pwrDown,
  input  logic                dout,
  output logic                din,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid
);
  logic [CMD_BITS-1:0] cmdShift;
  logic [RES_BITS-1:0] capShift;

  assign din = cmdShift[CMD_BITS-1];

  always_ff @(posedge clk) begin
    if (rst)                 cmdShift <= '0;
    else if (dpCtl.loadCmd)  cmdShift <= {1'b1, chanSel, uniPolar, singleEnded, pwrDown};
    else if (dpCtl.shiftCmd) cmdShift <= {cmdShift[CMD_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capShift    <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= dpCtl.pushResult;
      if (dpCtl.sampleBit) capShift <= {capShift[RES_BITS-2:0], dout};
      if (dpCtl.pushResult) result <= {capShift[RES_BITS-2:0], dout};
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) resultValid |=> !resultValid); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !resultValid |-> $stable(result)); // R8
endmodule

// File: rtl/adc_host.sv
module adc_host
  import adc_host_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ   = 125_000_000,
  parameter bit          SCLK_CAP_LOW = 1'b0,
  parameter int unsigned POWERUP_US   = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  input  logic [2:0]          chanSel,
  input  logic                uniPolar,
  input  logic                singleEnded,
  input  logic [1:0]          pwrDown,
  input  logic                dout,
  output logic                sclk,
  output logic                csN,
  output logic                din,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid
);
  localparam logic [POS_W-1:0] P_CMD = POS_W'(CMD_BITS);

  dpCtl_t           dpCtl;
  logic [POS_W-1:0] framePos;

  adc_host_ctrl #(
    .SYS_CLK_HZ  (SYS_CLK_HZ),
    .SCLK_CAP_LOW(SCLK_CAP_LOW),
    .POWERUP_US  (POWERUP_US)
  ) ctrl (
    .clk     (clk),
    .rst     (rst),
    .startReq(startReq),
    .sclk    (sclk),
    .csN     (csN),
    .framePos(framePos),
    .dpCtl   (dpCtl)
  );

  adc_host_dp dp (
    .clk        (clk),
    .rst        (rst),
    .dpCtl      (dpCtl),
    .chanSel    (chanSel),
    .uniPolar   (uniPolar),
    .singleEnded(singleEnded),
    .pwrDown    (pwrDown),
    .dout       (dout),
    .din        (din),
    .result     (result),
    .resultValid(resultValid)
  );

  AST_DIN_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst) (sclk && $past(sclk)) |-> $stable(din)); // R3
  AST_DIN_QUIET_LATE: assert property (@(posedge clk) disable iff (rst) (!csN && framePos > P_CMD) |-> !din); // R4
endmodule

// File: tb/tb_adc_host.sv
module tb_adc_host;
  localparam int SYS_HZ    = 125_000_000;
  localparam int HALF      = (SYS_HZ + 4_000_000 - 1) / 4_000_000;
  localparam int HALF_SLOW = (SYS_HZ + 800_000 - 1) / 800_000;
  localparam int WAIT_CYC  = (SYS_HZ / 1_000_000) * 100;
  localparam int FRAME     = 16;
  localparam int LIMIT     = 190_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic [2:0] chanSel;
  logic uniPolar, singleEnded;
  logic [1:0] pwrDown;
  logic dout;
  logic sclk, csN, din, resultValid;
  logic [9:0] result;
  logic sclk2, csN2, din2, valid2;
  logic [9:0] result2;

  always #4 clk = ~clk;

  adc_host dut (
    .clk(clk), .rst(rst), .startReq(startReq), .chanSel(chanSel), .uniPolar(uniPolar),
    .singleEnded(singleEnded), .pwrDown(pwrDown), .dout(dout), .sclk(sclk), .csN(csN),
    .din(din), .result(result), .resultValid(resultValid)
  );

  adc_host #(.SCLK_CAP_LOW(1'b1)) dut2 (
    .clk(clk), .rst(rst), .startReq(1'b1), .chanSel(3'd0), .uniPolar(1'b0),
    .singleEnded(1'b0), .pwrDown(2'd0), .dout(1'b0), .sclk(sclk2), .csN(csN2),
    .din(din2), .result(result2), .resultValid(valid2)
  );

  int errors = 0, checks = 0;
  int cyc = 0, cmdCnt = 0, sessCnt = 0;
  bit timeout = 1'b0;
  bit rx = 1'b0, armed = 1'b0, sessDinErr = 1'b0, r2Done = 1'b0, r5Done = 1'b0, r5Done2 = 1'b0;
  int rxN = 0, outLeft = 0, wrIdx = 0, rdIdx = 0;
  int sessRises = 0, sessValids = 0, lastValid = 0, riseCyc = 0, riseCyc2 = 0;
  logic [7:0] rxReg, snap;
  logic [11:0] outBuf;
  logic [9:0] expCode [0:255];
  logic prevSclk = 1'b0, prevSclk2 = 1'b0, prevCs = 1'b1, prevValid = 1'b0;

  function automatic logic [7:0] cmdByte(input logic [2:0] c, input logic u, input logic s, input logic [1:0] p);
    return {1'b1, c, u, s, p};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic newFields();
    chanSel     = 3'($urandom);
    uniPolar    = 1'($urandom);
    singleEnded = 1'($urandom);
    pwrDown     = 2'($urandom);
  endtask

  always @(negedge clk) begin
    if (rst) begin
      newFields();
      dout = 1'b0;
    end else begin
      cyc++;
      if (cyc == 3)  // R1 reset state
        chk(csN && !sclk && !din && !resultValid, "R1 reset outputs", {csN, sclk, din, resultValid}, 4'b1000);
      if (!csN && prevCs) begin
        if (!r2Done) begin  // R2 power-on wait
          chk(cyc >= WAIT_CYC && cyc <= WAIT_CYC + HALF + 2, "R2 first select", cyc, WAIT_CYC);
          r2Done = 1'b1;
        end
        sessRises = 0; sessValids = 0; sessDinErr = 1'b0;
      end
      if (sclk && !prevSclk) begin
        riseCyc = cyc;
        if (!csN) begin
          sessRises++;
          if (((sessRises - 1) % FRAME) + 1 > 8 && din) sessDinErr = 1'b1;
          if (armed) begin
            armed = 1'b0;
            outBuf = {10'($urandom), 2'($urandom)};
            expCode[wrIdx % 256] = outBuf[11:2];
            wrIdx++;
            outLeft = 12;
          end
          if (rx) begin
            rxReg = {rxReg[6:0], din};
            rxN++;
            if (rxN == 4) newFields();  // R10 fields move mid-frame
            if (rxN == 8) begin
              rx = 1'b0;
              chk(rxReg == snap, "R3 R10 command byte", rxReg, snap);
              cmdCnt++;
              armed = 1'b1;
            end
          end else if (din) begin
            rx = 1'b1; rxN = 1; rxReg = 8'h01;
            snap = cmdByte(chanSel, uniPolar, singleEnded, pwrDown);
          end
        end
      end
      if (!sclk && prevSclk) begin
        if (!r5Done) begin
          chk(cyc - riseCyc == HALF, "R5 half period fast", cyc - riseCyc, HALF);
          r5Done = 1'b1;
        end
        if (outLeft > 0) begin
          dout = outBuf[11];
          outBuf = {outBuf[10:0], 1'b0};
          outLeft--;
        end else dout = 1'b0;
      end
      if (sclk2 && !prevSclk2) riseCyc2 = cyc;
      if (!sclk2 && prevSclk2 && !r5Done2) begin
        chk(cyc - riseCyc2 == HALF_SLOW, "R5 half period slow", cyc - riseCyc2, HALF_SLOW);
        r5Done2 = 1'b1;
      end
      if (prevValid) chk(!resultValid, "R8 valid width", resultValid, 0);
      if (resultValid) begin
        chk(result == expCode[rdIdx % 256], "R7 result code", result, expCode[rdIdx % 256]);
        rdIdx++;
        if (sessValids > 0)  // R6 pipelined spacing
          chk(cyc - lastValid == 2 * HALF * FRAME, "R6 result spacing", cyc - lastValid, 2 * HALF * FRAME);
        lastValid = cyc;
        sessValids++;
      end
      if (csN && !prevCs) begin
        chk(sessRises == FRAME * sessValids + 8, "R9 session clocks", sessRises, FRAME * sessValids + 8);
        chk(!sessDinErr && !rx, "R4 idle data bits", {sessDinErr, rx}, 0);
        sessCnt++;
      end
      if (cyc == LIMIT && !timeout) begin
        chk(1'b0, "watchdog", cyc, LIMIT);
        timeout = 1'b1;
      end
      prevSclk = sclk; prevSclk2 = sclk2; prevCs = csN; prevValid = resultValid;
    end
  end

  initial begin
    int target;
    void'($urandom(32'd7351));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    startReq = 1'b1;
    target = 12;
    wait (cmdCnt >= target || timeout);
    startReq = 1'b0;
    wait (sessCnt >= 1 || timeout);
    startReq = 1'b1;
    target++;
    wait (cmdCnt >= target || timeout);
    startReq = 1'b0;
    wait (sessCnt >= 2 || timeout);
    for (int b = 0; b < 5; b++) begin
      repeat (1 + ($urandom % 50)) @(negedge clk);
      startReq = 1'b1;
      target += 1 + int'($urandom % 5);
      wait (cmdCnt >= target || timeout);
      startReq = 1'b0;
      wait (sessCnt >= 3 + b || timeout);
    end
    repeat (20) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule